// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This unit turns each bus cycle into a set of active-low select lines for four external regions. Every select has three registers, written through a small write-only register port: a base address, a mask that sets which address bits are ignored and which access kinds are refused, and a control word. At the start of a cycle the upper sixteen address bits and the access attributes are compared against all four select settings at once. The outcome, together with the wait count and acknowledge setting of the matching select, is captured for the whole cycle.

With exactly one hit, the select stays low until the cycle ends. The cycle ends either on an internal acknowledge, issued after the programmed number of wait clocks, or on the external acknowledge input. With two or more hits, every hit select goes low and only the external acknowledge can end the cycle. With no hit, nothing is driven and the cycle never completes. Only a reset clears it. Status outputs report which of the three outcomes the current cycle took.

Select 0 answers every address after reset, so that boot code can be fetched before any register is written. It leaves this global mode on the first write to its mask register.

Top module: `chipSelectUnit`

## Requirements
- R1: After reset all select lines are high, the three status outputs are low and `intAck` is low.
- R2: After reset, select 0 hits every address and attribute combination, with 15 wait clocks and internal acknowledge on. Its control register resets to 0x3D00.
- R3: The first write to the mask register of select 0 (`regSel`=0, `regKind`=1) ends its global mode. From then on select 0 hits only by the normal rule in R4 and R5.
- R4: Register kinds are 0 for base (data bits 15:0), 1 for mask (32 bits) and 2 for control (data bits 15:0). A select hits when mask bit 0 (enable) is 1 and `((cycAddr[31:16] ^ base) & ~mask[31:16]) == 0`.
- R5: `cycAttr` bit 0 marks a write and bit 1 marks a supervisor access. Mask bit 1 set refuses writes, and mask bit 2 set refuses non-supervisor accesses.
- R6: Control bits 13:10 hold the wait count W and bit 8 enables internal acknowledge. For a single hit with bit 8 set, the select is low for W+1 clocks and `intAck` is high for exactly the last one.
- R7: For a single hit with bit 8 clear, the cycle ends at the first clock edge at which `extAckN` is low, and `intAck` stays low.
- R8: For two or more hits, all hit selects are low, `matchMulti` is high, `intAck` stays low and the cycle ends on `extAckN` low.
- R9: With no hit, `matchNone` is high, no select goes low, `intAck` stays low and `extAckN` is ignored; the cycle persists until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Select whose register is written |
| regKind | input | 2 | Register kind: 0 base, 1 mask, 2 control |
| regData | input | 32 | Write data |
| cycValid | input | 1 | Bus cycle request, held until the cycle ends |
| cycAddr | input | 32 | Cycle address |
| cycAttr | input | 2 | Bit 0 write, bit 1 supervisor |
| extAckN | input | 1 | External transfer acknowledge, active low |
| selN | output | 4 | Chip-select lines, active low |
| intAck | output | 1 | Internal acknowledge pulse |
| matchNone | output | 1 | Current cycle hit no select |
| matchOne | output | 1 | Current cycle hit exactly one select |
| matchMulti | output | 1 | Current cycle hit several selects |

## Verification
The decoder is tried with an unprogrammed global boot access, with addresses inside and just outside a masked region, and with one address that two selects share. The overlapping address separates the multi-hit path from single hits. Reads, writes, user and supervisor attributes are run against selects that refuse writes or user accesses, which shows that attribute refusal can turn a double hit into a single hit or into no hit. Wait counts of 0, 1, 2 and 15 separate auto-acknowledged ends from externally ended ones. Miss cycles are held while the external acknowledge toggles, to confirm that they never finish.

// File: rtl/csuPkg.sv
package csuPkg;
  typedef struct packed {
    logic cycStart;
    logic cycEnd;
  } csuStrobes_t;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ONE   = 2'd1,
    CLS_MULTI = 2'd2
  } matchClass_e;

  localparam int KIND_BASE = 0;
  localparam int KIND_MASK = 1;
  localparam int KIND_CTRL = 2;

  localparam int MASK_EN_BIT   = 0;
  localparam int MASK_NOWR_BIT = 1;
  localparam int MASK_NOUSR_BIT = 2;

  localparam int CTRL_ACK_BIT  = 8;
  localparam int CTRL_WAIT_LSB = 10;

  localparam logic [15:0] SEL0_CTRL_RST = 16'h3D00;
endpackage

// File: rtl/csuDatapath.sv
module csuDatapath
  import csuPkg::*;
#(
  parameter int NUM_SEL = 4,
  parameter int ADDR_W  = 32,
  parameter int BASE_W  = 16,
  parameter int WAIT_W  = 4,
  parameter int ATTR_W  = 2,
  localparam int SEL_W  = $clog2(NUM_SEL),
  localparam int MASK_LSB = 32 - BASE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [1:0]         regKind,
  input  logic [31:0]        regData,
  input  logic [ADDR_W-1:0]  cycAddr,
  input  logic [ATTR_W-1:0]  cycAttr,
  input  csuStrobes_t        strobes,
  output logic [NUM_SEL-1:0] hitsNow,
  output logic [NUM_SEL-1:0] hitReg,
  output logic               waitDone,
  output logic               autoAckReg
);
  logic [BASE_W-1:0] baseReg [NUM_SEL];
  logic [31:0]       maskReg [NUM_SEL];
  logic [15:0]       ctrlReg [NUM_SEL];
  logic              globalMode;
  logic [WAIT_W-1:0] waitReg, waitCnt, selWait;
  logic              selAuto;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) globalMode <= 1'b1;
    else if (regWe && regSel == '0 && regKind == 2'(KIND_MASK)) globalMode <= 1'b0;
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    logic addrOk, attrOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseReg[g] <= '0;
        maskReg[g] <= '0;
        ctrlReg[g] <= (g == 0) ? SEL0_CTRL_RST : 16'h0000;
      end else if (regWe && regSel == SEL_W'(g)) begin
        case (regKind)
          2'(KIND_BASE): baseReg[g] <= regData[BASE_W-1:0];
          2'(KIND_MASK): maskReg[g] <= regData;
          2'(KIND_CTRL): ctrlReg[g] <= regData[15:0];
          default: ;
        endcase
      end
    end

    always_comb begin
      addrOk = ((cycAddr[ADDR_W-1 -: BASE_W] ^ baseReg[g]) & ~maskReg[g][31:MASK_LSB]) == '0;
      attrOk = !(maskReg[g][MASK_NOWR_BIT] && cycAttr[0]) &&
               !(maskReg[g][MASK_NOUSR_BIT] && !cycAttr[1]);
      hitsNow[g] = ((g == 0) && globalMode) ||
                   (maskReg[g][MASK_EN_BIT] && addrOk && attrOk);
    end
  end

  always_comb begin
    selWait = '0;
    selAuto = 1'b0;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (hitsNow[i]) begin
        selWait = selWait | ctrlReg[i][CTRL_WAIT_LSB +: WAIT_W];
        selAuto = selAuto | ctrlReg[i][CTRL_ACK_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitReg     <= '0;
      waitReg    <= '0;
      waitCnt    <= '0;
      autoAckReg <= 1'b0;
    end else if (strobes.cycStart) begin
      hitReg     <= hitsNow;
      waitReg    <= selWait;
      waitCnt    <= '0;
      autoAckReg <= selAuto;
    end else if (strobes.cycEnd) begin
      hitReg  <= '0;
    end else if (waitCnt != waitReg) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign waitDone = (waitCnt == waitReg);
endmodule

// File: rtl/csuControl.sv
module csuControl
  import csuPkg::*;
#(
  parameter int NUM_SEL = 4,
  localparam int CNT_W = $clog2(NUM_SEL + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycValid,
  input  logic               extAckN,
  input  logic [NUM_SEL-1:0] hitsNow,
  input  logic               waitDone,
  input  logic               autoAckReg,
  output csuStrobes_t        strobes,
  output logic               intAck,
  output matchClass_e        cls,
  output logic               active
);
  logic [CNT_W-1:0] hitCount;
  matchClass_e      nextCls;
  logic             extDone;

  always_comb begin
    hitCount = '0;
    for (int i = 0; i < NUM_SEL; i++) hitCount = hitCount + CNT_W'(hitsNow[i]);
    if (hitCount == '0)      nextCls = CLS_NONE;
    else if (hitCount == 1)  nextCls = CLS_ONE;
    else                     nextCls = CLS_MULTI;
  end

  assign intAck  = active && cls == CLS_ONE && autoAckReg && waitDone;
  assign extDone = active && !extAckN &&
                   ((cls == CLS_ONE && !autoAckReg) || cls == CLS_MULTI);

  assign strobes.cycStart = !active && cycValid;
  assign strobes.cycEnd   = intAck || extDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cls    <= CLS_NONE;
    end else if (strobes.cycStart) begin
      active <= 1'b1;
      cls    <= nextCls;
    end else if (strobes.cycEnd) begin
      active <= 1'b0;
      cls    <= CLS_NONE;
    end
  end
endmodule

// File: rtl/chipSelectUnit.sv
module chipSelectUnit
  import csuPkg::*;
#(
  parameter int NUM_SEL = 4,
  parameter int ADDR_W  = 32,
  parameter int BASE_W  = 16,
  parameter int WAIT_W  = 4,
  parameter int ATTR_W  = 2,
  localparam int SEL_W  = $clog2(NUM_SEL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [1:0]         regKind,
  input  logic [31:0]        regData,
  input  logic               cycValid,
  input  logic [ADDR_W-1:0]  cycAddr,
  input  logic [ATTR_W-1:0]  cycAttr,
  input  logic               extAckN,
  output logic [NUM_SEL-1:0] selN,
  output logic               intAck,
  output logic               matchNone,
  output logic               matchOne,
  output logic               matchMulti
);
  csuStrobes_t        strobes;
  logic [NUM_SEL-1:0] hitsNow, hitReg;
  logic               waitDone, autoAckReg, active;
  matchClass_e        cls;

  csuDatapath #(
    .NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W), .BASE_W(BASE_W),
    .WAIT_W(WAIT_W), .ATTR_W(ATTR_W)
  ) dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regKind(regKind), .regData(regData), .cycAddr(cycAddr),
    .cycAttr(cycAttr), .strobes(strobes), .hitsNow(hitsNow),
    .hitReg(hitReg), .waitDone(waitDone), .autoAckReg(autoAckReg)
  );

  csuControl #(.NUM_SEL(NUM_SEL)) ctl (
    .clk(clk), .rstN(rstN), .cycValid(cycValid), .extAckN(extAckN),
    .hitsNow(hitsNow), .waitDone(waitDone), .autoAckReg(autoAckReg),
    .strobes(strobes), .intAck(intAck), .cls(cls), .active(active)
  );

  assign selN       = ~hitReg;
  assign matchNone  = active && cls == CLS_NONE;
  assign matchOne   = active && cls == CLS_ONE;
  assign matchMulti = active && cls == CLS_MULTI;
endmodule

// File: rtl/csuChecker.sv
module csuChecker #(
  parameter int NUM_SEL = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               extAckN,
  input logic [NUM_SEL-1:0] selN,
  input logic               intAck,
  input logic               matchNone,
  input logic               matchOne,
  input logic               matchMulti
);
  p_status_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({matchNone, matchOne, matchMulti}));

  p_ack_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> matchOne);

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> !intAck);

  p_single_line_r6: assert property (@(posedge clk) disable iff (!rstN)
    matchOne |-> $countones(~selN) == 1);

  p_multi_lines_r8: assert property (@(posedge clk) disable iff (!rstN)
    matchMulti |-> ($countones(~selN) >= 2 && !intAck));

  p_none_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    matchNone |-> (&selN && !intAck));

  p_none_pending_r9: assert property (@(posedge clk) disable iff (!rstN)
    matchNone |=> matchNone);
endmodule

bind chipSelectUnit csuChecker #(.NUM_SEL(NUM_SEL)) chk (
  .clk(clk), .rstN(rstN), .extAckN(extAckN), .selN(selN), .intAck(intAck),
  .matchNone(matchNone), .matchOne(matchOne), .matchMulti(matchMulti)
);

// File: tb/chipSelectUnit_test.sv
module chipSelectUnit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = '0;
  logic [1:0]  regKind = '0;
  logic [31:0] regData = '0;
  logic        cycValid = 1'b0;
  logic [31:0] cycAddr = '0;
  logic [1:0]  cycAttr = '0;
  logic        extAckN = 1'b1;
  logic [3:0]  selN;
  logic        intAck, matchNone, matchOne, matchMulti;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [3:0] expSelN;
    logic [1:0] expCls;   // 1 single, 2 multi
    int         expLen;
    int         expAcks;
    string      req;
  } item_t;

  item_t expQ[$];

  chipSelectUnit uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regKind(regKind),
    .regData(regData), .cycValid(cycValid), .cycAddr(cycAddr), .cycAttr(cycAttr),
    .extAckN(extAckN), .selN(selN), .intAck(intAck), .matchNone(matchNone),
    .matchOne(matchOne), .matchMulti(matchMulti)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per observed single/multi cycle.
  initial begin
    bit    inCyc = 0;
    int    len = 0, acks = 0;
    item_t cur;
    forever begin
      @(negedge clk);
      if (!inCyc && (matchOne || matchMulti)) begin
        if (expQ.size() == 0) begin
          check(0, "R4", "unexpected cycle", {28'd0, selN}, 32'hF);
        end else begin
          cur = expQ.pop_front();
          check(selN == cur.expSelN, cur.req, "select lines", {28'd0, selN}, {28'd0, cur.expSelN});
          check({matchMulti, matchOne} == cur.expCls, cur.req, "match class",
                {30'd0, matchMulti, matchOne}, {30'd0, cur.expCls});
        end
        inCyc = 1; len = 1; acks = int'(intAck);
      end else if (inCyc && (matchOne || matchMulti)) begin
        len++; acks += int'(intAck);
      end else if (inCyc) begin
        inCyc = 0;
        check(len == cur.expLen, cur.req, "cycle length", len, cur.expLen);
        check(acks == cur.expAcks, cur.req, "internal acks", acks, cur.expAcks);
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [1:0] k, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = s; regKind = k; regData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // Driver: pushes the expected item, then runs the cycle.
  // extDelay 0 means the cycle is expected to end on intAck.
  task automatic runCycle(input logic [31:0] a, input logic [1:0] at,
                          input logic [3:0] eSel, input logic [1:0] eCls,
                          input int eLen, input int eAcks, input int extDelay,
                          input string req);
    item_t it;
    int n = 0;
    it.expSelN = eSel; it.expCls = eCls; it.expLen = eLen; it.expAcks = eAcks; it.req = req;
    expQ.push_back(it);
    @(negedge clk);
    cycAddr = a; cycAttr = at; cycValid = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      n++;
      if (extDelay == 0) begin
        if (intAck) begin cycValid = 1'b0; break; end
      end else if (n == extDelay) begin
        extAckN = 1'b0; cycValid = 1'b0;
        @(negedge clk);
        extAckN = 1'b1;
        break;
      end
    end
    cycValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkReset();
    check(selN == 4'hF, "R1", "selN after reset", {28'd0, selN}, 32'hF);
    check({matchNone, matchOne, matchMulti} == 3'b000, "R1", "status after reset",
          {29'd0, matchNone, matchOne, matchMulti}, 0);
    check(intAck == 1'b0, "R1", "intAck after reset", {31'd0, intAck}, 0);
  endtask

  // No-hit cycle: must hang while extAckN toggles, then reset clears it.
  task automatic noneCycle(input logic [31:0] a, input logic [1:0] at, input string req);
    int ackSeen = 0, lowSeen = 0;
    @(negedge clk);
    cycAddr = a; cycAttr = at; cycValid = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      extAckN = (i >= 4 && i < 7) ? 1'b0 : 1'b1;
      ackSeen += int'(intAck);
      if (selN != 4'hF) lowSeen++;
    end
    extAckN = 1'b1;
    check(matchNone == 1'b1, req, "no-hit still pending", {31'd0, matchNone}, 1);
    check(lowSeen == 0, "R9", "no select low on miss", lowSeen, 0);
    check(ackSeen == 0, "R9", "no intAck on miss", ackSeen, 0);
    cycValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();
  endtask

  initial begin
    #(200000 * 10);
    check(0, "R1", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();

    // R2: global boot select, W=15 with internal acknowledge
    runCycle(32'hDEAD_0000, 2'b01, 4'b1110, 2'd1, 16, 1, 0, "R2");

    // Program selects
    wr(2'd1, 2'd0, 32'h0000_1000);
    wr(2'd1, 2'd1, 32'h000F_0001);
    wr(2'd1, 2'd2, 32'h0000_0900);      // W=2, auto ack
    wr(2'd2, 2'd0, 32'h0000_2000);
    wr(2'd2, 2'd1, 32'h0000_0003);      // enable, refuse writes
    wr(2'd2, 2'd2, 32'h0000_0000);      // external ack
    wr(2'd3, 2'd0, 32'h0000_2000);
    wr(2'd3, 2'd1, 32'h00FF_0005);      // enable, refuse user
    wr(2'd3, 2'd2, 32'h0000_0500);      // W=1, auto ack
    wr(2'd0, 2'd2, 32'h0000_0100);      // W=0, auto ack
    wr(2'd0, 2'd1, 32'h0000_0001);      // R3: ends global mode

    // R3/R6: select 0 now limited to 0x0000xxxx, W=0
    runCycle(32'h0000_1234, 2'b10, 4'b1110, 2'd1, 1, 1, 0, "R3");
    // R4/R6: masked region of select 1, W=2
    runCycle(32'h100A_0000, 2'b10, 4'b1101, 2'd1, 3, 1, 0, "R6");
    // R7: external termination for single hit without auto ack
    runCycle(32'h2000_0010, 2'b00, 4'b1011, 2'd1, 4, 0, 4, "R7");
    // R8: supervisor read hits select 2 and 3
    runCycle(32'h2000_0000, 2'b10, 4'b0011, 2'd2, 3, 0, 3, "R8");
    // R5: user read refused by select 3, only select 2 hits
    runCycle(32'h2000_0000, 2'b00, 4'b1011, 2'd1, 2, 0, 2, "R5");
    // R4: mask on select 3 widens its region, W=1
    runCycle(32'h2001_0000, 2'b10, 4'b0111, 2'd2 - 2'd1, 2, 1, 0, "R4");

    // R9/R4: address just outside select 1 region
    noneCycle(32'h1010_0000, 2'b10, "R9");

    // After reset global mode is back (R2)
    runCycle(32'h7777_0000, 2'b00, 4'b1110, 2'd1, 16, 1, 0, "R2");

    // R3/R5: global off, select 2 refuses a write
    wr(2'd2, 2'd0, 32'h0000_2000);
    wr(2'd2, 2'd1, 32'h0000_0003);
    wr(2'd0, 2'd1, 32'h0000_0000);
    noneCycle(32'h2000_0000, 2'b11, "R5");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8", "all expected cycles seen", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule